// File: doc/BRIEF.md
# 3x3 Window Peak Finder Memory

This block is an on-chip memory for a 2-D array of unsigned scores or pixel values. Each search takes the coordinate of a window centre and returns the largest of the nine words around it, together with the absolute row and column where that word sits. Image rows are interleaved over three banks by row index modulo 3, so any three neighbouring rows come from three different banks. Each bank reads its three neighbouring columns in the same access and reduces them to one row maximum. A top-level stage then reduces the three row maxima to the window maximum. Both reductions use a most-significant-bit-first elimination comparator. The order in which the banks serve the window's rows rotates with the centre row.

Words are loaded through a write port that is always ready. Search requests and results use valid/ready handshakes. A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the result register is empty or is being drained in the same cycle, so a consumer that keeps `res_ready` high gets one search per cycle. While a result waits with `res_ready` low, the result stays frozen and no new request is taken. A centre on the outer border, or beyond it, is refused: it raises a one-cycle error pulse and produces no result.

Top module: `lmax_search_mem`

## Requirements
- R1: A write with `wr_valid` high stores `wr_data` at (`wr_row`, `wr_col`) at the clock edge. `wr_ready` is always high. A write with `wr_row` at or beyond the image height is dropped.
- R2: For an accepted in-range request, `res_max` equals the largest of the nine words at rows centre-1..centre+1 and columns centre-1..centre+1.
- R3: `res_row` and `res_col` give the absolute location of that maximum word.
- R4: When several window words share the maximum, the one with the lowest row wins, and within that row the one with the lowest column wins.
- R5: The result appears, with `res_valid` high, on the clock edge that follows the accepting edge.
- R6: With `res_ready` held high, a request is accepted in every cycle and every accepted in-range request yields exactly one result.
- R7: `req_ready` = !`res_valid` || `res_ready`. While `res_valid` is high and `res_ready` is low, `res_max`, `res_row` and `res_col` hold their values.
- R8: An accepted request whose centre row is outside 1..H-2, or whose centre column is outside 1..W-2, drives `req_err` high for exactly the next cycle and raises no `res_valid`.
- R9: A search and a write in the same cycle: the search sees the memory contents from before that write.
- R10: After reset, `res_valid` and `req_err` are low and `req_ready` is high.
- R11: Comparison is unsigned across the full word width, so 16'hFFFF beats 16'h8000, and 16'h8000 beats 16'h7FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write strobe |
| wr_ready | output | 1 | Write accepted, always high |
| wr_row | input | ROW_W | Row of the word being written |
| wr_col | input | COL_W | Column of the word being written |
| wr_data | input | DATA_W | Word being written |
| req_valid | input | 1 | Search request valid |
| req_ready | output | 1 | Search request can be taken |
| req_row | input | ROW_W | Window centre row |
| req_col | input | COL_W | Window centre column |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_max | output | DATA_W | Window maximum |
| res_row | output | ROW_W | Absolute row of the maximum |
| res_col | output | COL_W | Absolute column of the maximum |
| req_err | output | 1 | One-cycle pulse for a refused out-of-range centre |

## Verification
The bank checks assume that every word in a window being searched has been written since power-up. The bench therefore fills the whole image before it issues its first search. The assertions also assume that the request inputs stay stable around the clock edge. The bench changes every input only at the falling edge. Out-of-range centres reach the banks only while the accept condition is gated off, so the bench mixes such centres freely into its random traffic, together with random `res_ready` stalls and writes that land in the same cycle as a search.

// File: rtl/lmax_pkg.sv
package lmax_pkg;
  localparam int WIN = 3;

  typedef logic [1:0] idx3_t;

  // one-hot of three to index; the lowest set bit wins
  function automatic idx3_t oh3_to_idx(input logic [2:0] oh);
    if (oh[0]) return 2'd0;
    else if (oh[1]) return 2'd1;
    else return 2'd2;
  endfunction
endpackage

// File: rtl/lmax_bitcomp.sv
module lmax_bitcomp
  import lmax_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] cand [WIN],
  output logic [2:0]   win_oh,
  output logic [W-1:0] win_val
);
  logic [2:0] alive;
  logic [2:0] hit;

  // elimination from MSB down: a candidate with 0 where a survivor has 1 leaves
  always_comb begin
    alive = '1;
    for (int b = W - 1; b >= 0; b--) begin
      for (int k = 0; k < WIN; k++) hit[k] = alive[k] & cand[k][b];
      if (|hit) alive = hit;
    end
    if (alive[0])      win_oh = 3'b001;
    else if (alive[1]) win_oh = 3'b010;
    else               win_oh = 3'b100;
    win_val = cand[oh3_to_idx(win_oh)];
  end
endmodule

// File: rtl/lmax_bank.sv
module lmax_bank
  import lmax_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IMG_W  = 64,
  parameter int ROWS   = 16,
  localparam int LROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W  = $clog2(IMG_W),
  localparam int AW     = $clog2(ROWS * IMG_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LROW_W-1:0] wr_lrow,
  input  logic [COL_W-1:0]  wr_col,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [LROW_W-1:0] rd_lrow,
  input  logic [COL_W-1:0]  rd_col,
  output logic [DATA_W-1:0] row_max,
  output idx3_t             max_off
);
  logic [DATA_W-1:0] mem [ROWS * IMG_W];
  logic [DATA_W-1:0] words [WIN];
  logic [AW-1:0]     waddr;
  logic [AW-1:0]     rbase;
  logic [2:0]        pick_oh;

  assign waddr = AW'(wr_lrow) * AW'(IMG_W) + AW'(wr_col);
  assign rbase = AW'(rd_lrow) * AW'(IMG_W) + AW'(rd_col);

  always_ff @(posedge clk) begin
    if (wr_en) mem[waddr] <= wr_data;
  end

  // three consecutive columns of one row in the same access
  generate
    for (genvar k = 0; k < WIN; k++) begin : g_rd
      assign words[k] = mem[rbase - AW'(1) + AW'(k)];
    end
  endgenerate

  lmax_bitcomp #(.W(DATA_W)) u_rowcmp (
    .cand   (words),
    .win_oh (pick_oh),
    .win_val(row_max)
  );

  assign max_off = oh3_to_idx(pick_oh);

  // R2
  rowmax_ge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (row_max >= words[0] && row_max >= words[1] && row_max >= words[2]));
  // R3
  rowmax_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (max_off <= 2'd2 && row_max == words[max_off]));
endmodule

// File: rtl/lmax_search_mem.sv
module lmax_search_mem
  import lmax_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IMG_W  = 64,
  parameter int IMG_H  = 48,
  localparam int ROW_W   = $clog2(IMG_H),
  localparam int COL_W   = $clog2(IMG_W),
  localparam int ROWS_PB = (IMG_H + WIN - 1) / WIN,
  localparam int LROW_W  = (ROWS_PB > 1) ? $clog2(ROWS_PB) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [COL_W-1:0]  wr_col,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_max,
  output logic [ROW_W-1:0]  res_row,
  output logic [COL_W-1:0]  res_col,
  output logic              req_err
);
  logic              in_range, accept, go;
  logic [ROW_W-1:0]  slot_row  [WIN];
  idx3_t             slot_bank [WIN];
  logic [LROW_W-1:0] bank_lrow [WIN];
  logic [DATA_W-1:0] bank_max  [WIN];
  idx3_t             bank_off  [WIN];
  logic [DATA_W-1:0] slot_max  [WIN];
  idx3_t             slot_off  [WIN];
  logic [2:0]        top_oh;
  logic [DATA_W-1:0] top_max;
  idx3_t             top_slot;
  idx3_t             wr_bank;
  logic              wr_in_img;

  assign wr_ready  = 1'b1;
  assign in_range  = (req_row >= ROW_W'(1)) && (req_row <= ROW_W'(IMG_H - 2)) &&
                     (req_col >= COL_W'(1)) && (req_col <= COL_W'(IMG_W - 2));
  assign req_ready = !res_valid || res_ready;
  assign accept    = req_valid && req_ready;
  assign go        = accept && in_range;

  assign wr_bank   = idx3_t'(int'(wr_row) % WIN);
  assign wr_in_img = int'(wr_row) < IMG_H;

  // window slot k holds row centre-1+k; its bank rotates with the centre row
  always_comb begin
    for (int k = 0; k < WIN; k++) begin
      slot_row[k]  = req_row - ROW_W'(1) + ROW_W'(k);
      slot_bank[k] = idx3_t'(int'(slot_row[k]) % WIN);
    end
    for (int b = 0; b < WIN; b++) begin
      bank_lrow[b] = '0;
      for (int k = 0; k < WIN; k++)
        if (int'(slot_bank[k]) == b) bank_lrow[b] = LROW_W'(int'(slot_row[k]) / WIN);
    end
    for (int k = 0; k < WIN; k++) begin
      slot_max[k] = bank_max[0];
      slot_off[k] = bank_off[0];
      for (int b = 1; b < WIN; b++)
        if (int'(slot_bank[k]) == b) begin
          slot_max[k] = bank_max[b];
          slot_off[k] = bank_off[b];
        end
    end
  end

  generate
    for (genvar b = 0; b < WIN; b++) begin : g_bank
      lmax_bank #(.DATA_W(DATA_W), .IMG_W(IMG_W), .ROWS(ROWS_PB)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_valid && wr_in_img && (int'(wr_bank) == b)),
        .wr_lrow(LROW_W'(int'(wr_row) / WIN)),
        .wr_col (wr_col),
        .wr_data(wr_data),
        .rd_en  (go),
        .rd_lrow(bank_lrow[b]),
        .rd_col (req_col),
        .row_max(bank_max[b]),
        .max_off(bank_off[b])
      );
    end
  endgenerate

  // slots are ordered by row, so the lowest row wins a tie
  lmax_bitcomp #(.W(DATA_W)) u_topcmp (
    .cand   (slot_max),
    .win_oh (top_oh),
    .win_val(top_max)
  );

  assign top_slot = oh3_to_idx(top_oh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      req_err   <= 1'b0;
      res_max   <= '0;
      res_row   <= '0;
      res_col   <= '0;
    end else begin
      req_err <= accept && !in_range;
      if (go) begin
        res_valid <= 1'b1;
        res_max   <= top_max;
        res_row   <= req_row - ROW_W'(1) + ROW_W'(top_slot);
        res_col   <= req_col - COL_W'(1) + COL_W'(slot_off[top_slot]);
      end else if (res_ready) begin
        res_valid <= 1'b0;
      end
    end
  end

  // R2
  topmax_ge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (top_max >= slot_max[0] && top_max >= slot_max[1] && top_max >= slot_max[2]));
  // R5
  result_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> res_valid);
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_max) && $stable(res_row) && $stable(res_col)));
  // R8
  err_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> !res_valid);
  // R3
  row_near_centre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (res_row >= $past(req_row) - ROW_W'(1) && res_row <= $past(req_row) + ROW_W'(1)));
endmodule

// File: tb/lmax_search_mem_tb.sv
module lmax_search_mem_tb_top;
  localparam int DW = 16;
  localparam int W  = 64;
  localparam int H  = 48;
  localparam int RW = $clog2(H);
  localparam int CW = $clog2(W);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0, req_valid = 1'b0, res_ready = 1'b0;
  logic [RW-1:0] wr_row = '0, req_row = '0;
  logic [CW-1:0] wr_col = '0, req_col = '0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_ready, req_ready, res_valid, req_err;
  logic [DW-1:0] res_max;
  logic [RW-1:0] res_row;
  logic [CW-1:0] res_col;

  always #4 clk = ~clk;

  lmax_search_mem #(.DATA_W(DW), .IMG_W(W), .IMG_H(H)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_row(req_row), .req_col(req_col),
    .res_valid(res_valid), .res_ready(res_ready), .res_max(res_max),
    .res_row(res_row), .res_col(res_col), .req_err(req_err)
  );

  int total = 0, bad = 0;
  bit done = 0;
  int model [H][W];
  bit e_valid = 0, e_err = 0;
  int e_max = 0, e_row = 0, e_col = 0;
  bit dir_on = 0;
  int dir_max, dir_row, dir_col;
  string dir_tag;
  int issued = 0, seen = 0;
  bit last_rdy = 0;
  int unsigned seed = 32'h1234_5678;

  function automatic int unsigned rnd();
    seed = seed * 1103515245 + 12345;
    return seed >> 8;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic ref_search(input int r, input int c, output int mx, output int mr, output int mc);
    mx = -1; mr = 0; mc = 0;
    for (int i = r - 1; i <= r + 1; i++)
      for (int j = c - 1; j <= c + 1; j++)
        if (model[i][j] > mx) begin mx = model[i][j]; mr = i; mc = j; end
  endtask

  task automatic cyc(input bit wv, input int wr, input int wc, input int wd,
                     input bit rv, input int rr, input int rc, input bit rdy);
    bit ready_e, acc, ok, n_valid, n_err;
    int n_max, n_row, n_col;
    @(negedge clk);
    chk(res_valid === e_valid, "R5", "res_valid", int'(res_valid), int'(e_valid));
    chk(req_err === e_err, "R8", "req_err", int'(req_err), int'(e_err));
    chk(wr_ready === 1'b1, "R1", "wr_ready", int'(wr_ready), 1);
    if (e_valid) begin
      chk(int'(res_max) == e_max, "R2", "res_max", int'(res_max), e_max);
      chk(int'(res_row) == e_row && int'(res_col) == e_col, "R3", "res_row*W+res_col",
          int'(res_row) * W + int'(res_col), e_row * W + e_col);
    end
    if (dir_on) begin
      chk(res_valid === 1'b1 && int'(res_max) == dir_max && int'(res_row) == dir_row &&
          int'(res_col) == dir_col, dir_tag, "directed max/row*W+col",
          int'(res_max) * 4096 + int'(res_row) * W + int'(res_col), dir_max * 4096 + dir_row * W + dir_col);
      dir_on = 0;
    end
    if (res_valid === 1'b1 && last_rdy) seen++;
    wr_valid = wv; wr_row = RW'(wr); wr_col = CW'(wc); wr_data = DW'(wd);
    req_valid = rv; req_row = RW'(rr); req_col = CW'(rc); res_ready = rdy;
    #1;
    ready_e = !e_valid || rdy;
    chk(req_ready === ready_e, "R7", "req_ready", int'(req_ready), int'(ready_e));
    acc = rv && ready_e;
    ok = rr >= 1 && rr <= H - 2 && rc >= 1 && rc <= W - 2;
    n_err = acc && !ok;
    n_valid = e_valid; n_max = e_max; n_row = e_row; n_col = e_col;
    if (acc && ok) begin
      ref_search(rr, rc, n_max, n_row, n_col);
      n_valid = 1;
      issued++;
    end else if (rdy) n_valid = 0;
    if (wv && wr < H) model[wr][wc] = wd & 16'hFFFF;
    e_valid = n_valid; e_err = n_err; e_max = n_max; e_row = n_row; e_col = n_col;
    last_rdy = rdy;
  endtask

  task automatic idle(input bit rdy);
    cyc(0, 0, 0, 0, 0, 0, 0, rdy);
  endtask

  task automatic put(input int r, input int c, input int d);
    cyc(1, r, c, d, 0, 0, 0, 1);
  endtask

  task automatic fill_win(input int r, input int c, input int d);
    for (int i = r - 1; i <= r + 1; i++)
      for (int j = c - 1; j <= c + 1; j++) put(i, j, d);
  endtask

  task automatic expect_dir(input string tag, input int mx, input int r, input int c);
    dir_on = 1; dir_tag = tag; dir_max = mx; dir_row = r; dir_col = c;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=expired expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    repeat (2) @(negedge clk);
    chk(res_valid === 1'b0, "R10", "res_valid", int'(res_valid), 0);
    chk(req_err === 1'b0, "R10", "req_err", int'(req_err), 0);
    res_ready = 1'b0;
    #1;
    chk(req_ready === 1'b1, "R10", "req_ready", int'(req_ready), 1);
    rst_n = 1'b1;

    // R1: load the whole image
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) put(r, c, int'(rnd() & 16'hFFFF));
    put(H, 3, 16'hFFFF); // R1: row beyond image dropped

    // R6: one search per cycle with res_ready held high
    idle(1);
    issued = 0; seen = 0;
    for (int n = 0; n < 200; n++)
      cyc(0, 0, 0, 0, 1, 1 + int'(rnd() % (H - 2)), 1 + int'(rnd() % (W - 2)), 1);
    idle(1);
    idle(1);
    chk(seen == issued && issued == 200, "R6", "results seen", seen, issued);

    // R4: full tie picks top-left; row tie beats a lower column
    fill_win(10, 10, 500);
    cyc(0, 0, 0, 0, 1, 10, 10, 1);
    expect_dir("R4", 500, 9, 9);
    fill_win(20, 30, 100);
    put(20, 31, 777);
    put(21, 29, 777);
    cyc(0, 0, 0, 0, 1, 20, 30, 1);
    expect_dir("R4", 777, 20, 31);
    put(19, 31, 777);
    cyc(0, 0, 0, 0, 1, 20, 30, 1);
    expect_dir("R4", 777, 19, 31);

    // R11: unsigned full-width compare
    fill_win(30, 40, 5);
    put(30, 40, 16'h7FFF);
    put(31, 39, 16'h8000);
    cyc(0, 0, 0, 0, 1, 30, 40, 1);
    expect_dir("R11", 16'h8000, 31, 39);
    put(29, 41, 16'hFFFF);
    cyc(0, 0, 0, 0, 1, 30, 40, 1);
    expect_dir("R11", 16'hFFFF, 29, 41);

    // R9: a write in the same cycle as the search is not seen
    fill_win(5, 5, 3);
    cyc(1, 5, 5, 60000, 1, 5, 5, 1);
    expect_dir("R9", 3, 4, 4);
    cyc(0, 0, 0, 0, 1, 5, 5, 1);
    expect_dir("R9", 60000, 5, 5);

    // R8: border centres refused; the innermost legal corners accepted
    cyc(0, 0, 0, 0, 1, 0, 5, 1);
    cyc(0, 0, 0, 0, 1, H - 1, 5, 1);
    cyc(0, 0, 0, 0, 1, 5, 0, 1);
    cyc(0, 0, 0, 0, 1, 5, W - 1, 1);
    cyc(0, 0, 0, 0, 1, 63, 63, 1);
    cyc(0, 0, 0, 0, 1, H - 2, W - 2, 1);
    cyc(0, 0, 0, 0, 1, 1, 1, 1);
    idle(1);

    // R7: random stalls, mixed writes and refused centres
    for (int n = 0; n < 1500; n++) begin
      bit wv, rdy;
      wv = (rnd() % 3) == 0;
      rdy = (rnd() % 4) != 0;
      cyc(wv, int'(rnd() % H), int'(rnd() % W), int'(rnd() & 16'hFFFF),
          (rnd() % 4) != 0, int'(rnd() % (H + 4)), int'(rnd() % W), rdy);
    end
    idle(0);
    idle(1);
    idle(1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule